// File: doc/BRIEF.md
# Shared Interrupt Affinity Routing Table

This block keeps one 64-bit routing register for every shared interrupt (interrupt numbers 32 and up). Software writes an affinity value into a register to choose which core should receive that interrupt. The block packs the written affinity into a 32-bit word and stores it, and a later read returns the stored word. In the same clock edge the block resolves the affinity to a core index. It looks the value up in a per-core affinity table that is fixed by a parameter. It also keeps a target bitmap that holds one bit per interrupt per core.

The outputs give, for each shared interrupt, the resolved 8-bit core index, a valid flag, and that interrupt's column of the target bitmap. The delivery logic downstream consumes these outputs. A write moves the interrupt from its old core to its new core. An affinity that matches no core leaves the interrupt with no target. The index then holds the reserved value 0xFF, so the interrupt can still be marked pending but is never delivered.

Register accesses arrive as single-cycle requests. A small two-state machine returns read data:
- `RT_IDLE` moves to `RT_RESP` on a read request.
- `RT_RESP` stays in `RT_RESP` on another read request, and otherwise returns to `RT_IDLE`.
- `rd_valid_o` is high exactly while the machine is in `RT_RESP`.

Top module: `rt_spi_router`

## Requirements
- R1: The low word of the routing register for shared interrupt 32+k is at byte offset 0x6100 + 8*k, for k from 0 to NUM_SPI-1. All accesses are 32 bits wide. A read of any other offset returns zero, including offsets below 0x6100, offsets past the last register, and offsets not aligned to 4. A write to any other offset changes no output.
- R2: The upper word of each routing register (offset 0x6104 + 8*k) reads as zero, and a write to it changes no stored affinity and no target output.
- R3: A write stores the affinity with level 0 in bits [7:0], level 1 in [15:8] and level 2 in [23:16]. Level 3, in bits [31:24], is stored as zero because it cannot be written. A read returns the written bits [23:0], with bits [31:24] at zero.
- R4: A write whose packed affinity equals an entry of the core table clears the interrupt's bit in the old core's map, if there was one. It then sets the bit in the new core's map and sets the index to the new core with the valid flag at 1. Each interrupt has at most one map bit set at any time. The map bit for core c and interrupt k is tgt_map_o[c*NUM_SPI + k].
- R5: A write whose affinity matches no table entry clears the old map bit and sets the index to 0xFF and the valid flag to 0. No map bit is left set for that interrupt, and the written affinity still reads back.
- R6: After reset every interrupt routes to core 0 with the valid flag at 1 and core 0's map bit set. Its stored affinity equals core 0's table entry.
- R7: When several table entries equal the written affinity, the lowest core index is chosen.
- R8: A write changes the target outputs on the clock edge that accepts it, so the change appears in the following cycle and not before. Read data and rd_valid_o appear in the cycle after the read request, and rd_valid_o stays low in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Register access request this cycle |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | 16 | Byte offset of the access |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read |
| rd_data_o | output | 32 | Read data |
| tgt_core_o | output | NUM_SPI*8 | Resolved core index per interrupt, interrupt k in bits [8k+7:8k] |
| tgt_valid_o | output | NUM_SPI | 1 if interrupt k has a deliverable target |
| tgt_map_o | output | NUM_CORES*NUM_SPI | Target bitmap, bit c*NUM_SPI+k for core c and interrupt k |

## Verification
The hardest case to reach from the ports is a tie in the lookup. With the default table no two cores share an affinity, so the bench instantiates the block with a table in which cores 2 and 3 hold the same value and checks that core 2 wins. The bench also steers one interrupt to an unmatched affinity and then back to a real core. This checks that no stale map bit survives and that the "no target" state clears correctly. Every vector is followed by a check of all interrupts against a model, so a write that disturbs a neighbour's column is caught.

// File: rtl/rt_pkg.sv
package rt_pkg;

    localparam int unsigned CORE_W = 8;
    localparam logic [CORE_W-1:0] CORE_NONE = 8'hFF;
    localparam int unsigned AFF_W = 32;

    typedef enum logic {
        RT_IDLE,
        RT_RESP
    } rt_state_e;

    // Packs the low register word into the stored affinity form.
    // Level 3 sits in the upper register half, which is not writable.
    function automatic logic [AFF_W-1:0] pack_affinity(input logic [31:0] low_word);
        logic [AFF_W-1:0] p;
        p[7:0]   = low_word[7:0];
        p[15:8]  = low_word[15:8];
        p[23:16] = low_word[23:16];
        p[31:24] = 8'h00;
        return p;
    endfunction

endpackage

// File: rtl/rt_aff_match.sv
module rt_aff_match
    import rt_pkg::*;
#(
    parameter int unsigned NUM_CORES = 4,
    parameter logic [NUM_CORES*AFF_W-1:0] CORE_AFF = '0
) (
    input  logic [AFF_W-1:0]  aff_i,
    output logic              hit_o,
    output logic [CORE_W-1:0] idx_o
);

    logic [NUM_CORES-1:0] eq;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_cmp
        assign eq[c] = (CORE_AFF[c*AFF_W +: AFF_W] == aff_i);
    end

    // Scan from the top down so the lowest matching index is the last one written.
    always_comb begin
        hit_o = 1'b0;
        idx_o = CORE_NONE;
        for (int c = NUM_CORES - 1; c >= 0; c--) begin
            if (eq[c]) begin
                hit_o = 1'b1;
                idx_o = CORE_W'(c);
            end
        end
    end

endmodule

// File: rtl/rt_route_store.sv
module rt_route_store
    import rt_pkg::*;
#(
    parameter int unsigned NUM_SPI   = 8,
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned IDX_W     = 3,
    parameter logic [AFF_W-1:0] RESET_AFF = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [IDX_W-1:0]             wr_idx_i,
    input  logic [AFF_W-1:0]             wr_aff_i,
    input  logic                         new_hit_i,
    input  logic [CORE_W-1:0]            new_core_i,
    output logic [NUM_SPI*AFF_W-1:0]     aff_o,
    output logic [NUM_SPI*CORE_W-1:0]    core_o,
    output logic [NUM_SPI-1:0]           valid_o,
    output logic [NUM_CORES*NUM_SPI-1:0] map_o
);

    localparam int unsigned CSEL_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    logic [AFF_W-1:0]     aff_q   [NUM_SPI];
    logic [CORE_W-1:0]    core_q  [NUM_SPI];
    logic [NUM_SPI-1:0]   valid_q;
    logic [NUM_CORES-1:0] map_q   [NUM_SPI];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_SPI; k++) begin
                aff_q[k]  <= RESET_AFF;
                core_q[k] <= '0;
                map_q[k]  <= NUM_CORES'(1);
            end
            valid_q <= '1;
        end else if (wr_en_i) begin
            aff_q[wr_idx_i] <= wr_aff_i;
            // First drop the interrupt from its current core, then add it to the new one.
            for (int c = 0; c < NUM_CORES; c++) begin
                if (valid_q[wr_idx_i] && core_q[wr_idx_i] == CORE_W'(c))
                    map_q[wr_idx_i][c] <= 1'b0;
                if (new_hit_i && new_core_i == CORE_W'(c))
                    map_q[wr_idx_i][c] <= 1'b1;
            end
            if (new_hit_i) begin
                core_q[wr_idx_i]  <= new_core_i;
                valid_q[wr_idx_i] <= 1'b1;
            end else begin
                core_q[wr_idx_i]  <= CORE_NONE;
                valid_q[wr_idx_i] <= 1'b0;
            end
        end
    end

    for (genvar k = 0; k < NUM_SPI; k++) begin : g_out
        assign aff_o[k*AFF_W +: AFF_W]   = aff_q[k];
        assign core_o[k*CORE_W +: CORE_W] = core_q[k];
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_map
            assign map_o[c*NUM_SPI + k] = map_q[k][c];
        end

        // R4: one map bit exactly when the interrupt has a target
        assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(map_q[k]) == int'(valid_q[k]));

        // R4: a valid target has its own map bit set
        assert_target_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q[k] |-> (core_q[k] < CORE_W'(NUM_CORES)) && map_q[k][core_q[k][CSEL_W-1:0]]);

        // R5: no target means the reserved index
        assert_none_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_q[k] |-> core_q[k] == CORE_NONE);
    end

    assign valid_o = valid_q;

    // R8: a write is visible in the following cycle
    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (valid_q[$past(wr_idx_i)] == $past(new_hit_i))
                 && (aff_q[$past(wr_idx_i)] == $past(wr_aff_i)));

endmodule

// File: rtl/rt_spi_router.sv
module rt_spi_router
    import rt_pkg::*;
#(
    parameter int unsigned NUM_SPI   = 8,
    parameter int unsigned NUM_CORES = 4,
    parameter logic [15:0] ROUTE_BASE = 16'h6100,
    parameter logic [NUM_CORES*AFF_W-1:0] CORE_AFF =
        {32'h0001_0000, 32'h0000_0100, 32'h0000_0001, 32'h0000_0000}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid_i,
    input  logic                         req_write_i,
    input  logic [15:0]                  req_addr_i,
    input  logic [31:0]                  req_wdata_i,
    output logic                         rd_valid_o,
    output logic [31:0]                  rd_data_o,
    output logic [NUM_SPI*CORE_W-1:0]    tgt_core_o,
    output logic [NUM_SPI-1:0]           tgt_valid_o,
    output logic [NUM_CORES*NUM_SPI-1:0] tgt_map_o
);

    localparam int unsigned IDX_W = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;
    localparam int unsigned SPAN  = NUM_SPI * 8;

    // Address decode
    logic [16:0]      rel;
    logic             in_range;
    logic             upper_half;
    logic [IDX_W-1:0] reg_idx;
    logic             rd_req;
    logic             wr_low;

    assign rel        = {1'b0, req_addr_i} - {1'b0, ROUTE_BASE};
    assign in_range   = !rel[16] && (rel < 17'(SPAN)) && (req_addr_i[1:0] == 2'b00);
    assign upper_half = rel[2];
    assign reg_idx    = rel[3 +: IDX_W];
    assign rd_req     = req_valid_i && !req_write_i;
    assign wr_low     = req_valid_i && req_write_i && in_range && !upper_half;

    // Affinity lookup
    logic [AFF_W-1:0]  new_aff;
    logic              lk_hit;
    logic [CORE_W-1:0] lk_idx;

    assign new_aff = pack_affinity(req_wdata_i);

    rt_aff_match #(
        .NUM_CORES (NUM_CORES),
        .CORE_AFF  (CORE_AFF)
    ) u_match (
        .aff_i (new_aff),
        .hit_o (lk_hit),
        .idx_o (lk_idx)
    );

    // Routing storage and target bitmap
    logic [NUM_SPI*AFF_W-1:0] aff_flat;

    rt_route_store #(
        .NUM_SPI   (NUM_SPI),
        .NUM_CORES (NUM_CORES),
        .IDX_W     (IDX_W),
        .RESET_AFF (CORE_AFF[AFF_W-1:0])
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_low),
        .wr_idx_i   (reg_idx),
        .wr_aff_i   (new_aff),
        .new_hit_i  (lk_hit),
        .new_core_i (lk_idx),
        .aff_o      (aff_flat),
        .core_o     (tgt_core_o),
        .valid_o    (tgt_valid_o),
        .map_o      (tgt_map_o)
    );

    // Read response state machine
    rt_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RT_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = RT_IDLE;
        unique case (st_q)
            RT_IDLE: if (rd_req) st_d = RT_RESP;
            RT_RESP: if (rd_req) st_d = RT_RESP;
        endcase
    end

    always_comb begin
        rd_valid_o = (st_q == RT_RESP);
    end

    logic [31:0] rd_data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (rd_req) begin
            if (in_range && !upper_half)
                rd_data_q <= aff_flat[32*int'(reg_idx) +: 32];
            else
                rd_data_q <= '0;
        end
    end

    assign rd_data_o = rd_data_q;

    // R2: upper-half writes leave every target output untouched
    assert_upper_wi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && in_range && upper_half)
        |=> $stable(tgt_core_o) && $stable(tgt_valid_o) && $stable(tgt_map_o));

    // R2: upper half reads as zero
    assert_upper_raz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && in_range && upper_half) |=> rd_data_o == 32'h0);

    // R1: writes outside the table are ignored
    assert_oor_wi_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && !in_range)
        |=> $stable(tgt_core_o) && $stable(tgt_valid_o) && $stable(tgt_map_o));

    // R8: read response timing
    assert_rsp_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid_o);
    assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid_o);

    // R7: a reported hit names a core whose table entry really equals the affinity
    assert_hit_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (CORE_AFF[32*int'(lk_idx) +: 32] == new_aff));

endmodule

// File: tb/tb_rt_spi_router.sv
module tb_rt_spi_router;

    localparam int unsigned NSPI  = 8;
    localparam int unsigned NCORE = 4;
    // Cores 2 and 3 share an affinity so the tie rule can be seen.
    localparam logic [NCORE*32-1:0] TB_AFF =
        {32'h0001_0200, 32'h0001_0200, 32'h0000_00A1, 32'h0000_00A0};

    // Vector: {addr[63:48], wdata[47:16], exp_core[15:8], 7'b0, exp_valid[0]}
    localparam int NVEC = 8;
    localparam logic [63:0] VEC [NVEC] = '{
        {16'h6100, 32'h0000_00A1, 8'd1,  8'h01},  // R4 move to core 1
        {16'h6138, 32'h0001_0200, 8'd2,  8'h01},  // R7 tie -> core 2
        {16'h6118, 32'h0000_0055, 8'hFF, 8'h00},  // R5 no match
        {16'h6118, 32'h0000_00A0, 8'd0,  8'h01},  // R5 recover to core 0
        {16'h6128, 32'hFF00_00A1, 8'd1,  8'h01},  // R3 bits 31:24 dropped
        {16'h6100, 32'h0000_0000, 8'hFF, 8'h00},  // R5 leave core 1
        {16'h6108, 32'h0000_00A0, 8'd0,  8'h01},  // R4 same core again
        {16'h6100, 32'h0001_0200, 8'd2,  8'h01}   // R4 from none to core 2
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rd_valid;
    logic [31:0] rd_data;
    logic [NSPI*8-1:0] tgt_core;
    logic [NSPI-1:0] tgt_valid;
    logic [NCORE*NSPI-1:0] tgt_map;

    always #10 clk = ~clk;

    rt_spi_router #(
        .NUM_SPI   (NSPI),
        .NUM_CORES (NCORE),
        .ROUTE_BASE(16'h6100),
        .CORE_AFF  (TB_AFF)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .rd_valid_o  (rd_valid),
        .rd_data_o   (rd_data),
        .tgt_core_o  (tgt_core),
        .tgt_valid_o (tgt_valid),
        .tgt_map_o   (tgt_map)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0]  m_core [NSPI];
    logic        m_val  [NSPI];
    logic [31:0] m_aff  [NSPI];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NSPI; k++) begin
            m_core[k] = 8'd0;
            m_val[k]  = 1'b1;
            m_aff[k]  = TB_AFF[31:0];
        end
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < NSPI; k++) begin
            logic [NCORE-1:0] col, ecol;
            for (int c = 0; c < NCORE; c++) begin
                col[c]  = tgt_map[c*NSPI + k];
                ecol[c] = m_val[k] && (m_core[k] == 8'(c));
            end
            chk(tgt_core[k*8 +: 8] == m_core[k] && tgt_valid[k] == m_val[k] && col == ecol,
                req, $sformatf("interrupt %0d core/valid/map", k),
                {47'd0, tgt_core[k*8 +: 8], tgt_valid[k], col, 4'd0},
                {47'd0, m_core[k], m_val[k], ecol, 4'd0});
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        v = rd_valid; d = rd_data;
        req_valid = 1'b0;
    endtask

    task automatic read_expect(input logic [15:0] a, input logic [31:0] e, input string req);
        logic [31:0] d;
        logic v;
        do_read(a, d, v);
        chk(v == 1'b1 && d == e, req, $sformatf("read %04h", a), {31'd0, v, d}, {31'd1, 1'b1, e});
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: reset routing to core 0
        check_all("R6");
        read_expect(16'h6100, 32'h0000_00A0, "R6");
        read_expect(16'h6138, 32'h0000_00A0, "R6");
        // R8: no response without a read
        @(negedge clk);
        chk(rd_valid == 1'b0, "R8", "idle rd_valid", {63'd0, rd_valid}, 64'd0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] a;
            logic [31:0] d;
            int k;
            a = VEC[i][63:48];
            d = VEC[i][47:16];
            k = int'(a - 16'h6100) >> 3;
            do_write(a, d);
            m_aff[k]  = {8'h00, d[23:0]};
            m_core[k] = VEC[i][15:8];
            m_val[k]  = VEC[i][0];
            check_all("R4");
            read_expect(a, m_aff[k], "R3");
        end

        // R2: upper half
        do_write(16'h6104, 32'h0000_00A1);
        check_all("R2");
        read_expect(16'h6104, 32'h0, "R2");
        read_expect(16'h6100, m_aff[0], "R2");

        // R1: outside the table
        do_write(16'h60F8, 32'h0000_00A1);
        do_write(16'h6140, 32'h0000_00A1);
        do_write(16'h6111, 32'h0000_00A1);
        check_all("R1");
        read_expect(16'h6140, 32'h0, "R1");
        read_expect(16'h6000, 32'h0, "R1");
        read_expect(16'h6111, 32'h0, "R1");

        // R8: write effect appears only after the accepting edge
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h6110; req_wdata = 32'h0000_00A1;
        #5;
        chk(tgt_core[2*8 +: 8] == 8'd0, "R8", "core before edge", {56'd0, tgt_core[2*8 +: 8]}, 64'd0);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        m_core[2] = 8'd1; m_aff[2] = 32'h0000_00A1;
        check_all("R8");
        @(negedge clk);
        chk(rd_valid == 1'b0, "R8", "rd_valid after write", {63'd0, rd_valid}, 64'd0);

        // R6: reset again restores everything
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_reset();
        check_all("R6");
        read_expect(16'h6100, 32'h0000_00A0, "R6");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule